// File: doc/BRIEF.md
# Flash Censorship and Access-Protection Controller

This block decides whether the access-protection settings of the flash can be changed for bus masters other than the processor core. The decision depends on three things. The first is the boot configuration captured during reset. The second is a 32-bit censorship word. The third is the external-master enable bit. The access-protection register holds one field per bus master. The core's field always accepts writes. The other fields accept writes only when the censorship rules permit it. If a write to the register is refused, the block raises a one-cycle denied flag. Any permitted fields in that same write still update.

While reset is held, the block samples the censorship word and fixes the boot configuration. If the reset-configuration select input is low, the block derives the boot configuration from the lower half of the word. If the select input is high, the configuration is taken from the boot pins. Both values are then held until the next reset.

The block also holds a small control register with program, erase and stop bits. The stop bit drives the output that switches off the flash current sources. Writes to the stop bit are refused while a program or erase is flagged.

Top module: `flash_censor_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the following: the protection register, the PGM, ERS and STOP bits, and the denied flag.
- R2: A write to address 1 always loads the core master's field (bits 7:0) from the write data, whatever the censorship state.
- R3: When external-master enable is 0, a write to address 1 loads every master field.
- R4: When external-master enable is 1 and the boot configuration is 00, 10 or 11, the non-core fields load only if bits 31:16 of the sampled censorship word equal 0x55AA.
- R5: When external-master enable is 1 and the boot configuration is 01, the non-core fields never load, whatever the censorship word holds.
- R6: A refused write to address 1 keeps the non-core fields unchanged. It also sets the denied flag for exactly the cycle after the write. The flag is 0 at all other times.
- R7: During reset with the select input low, the boot configuration becomes 01 if bits 15:0 of the word are 0xFFFF or 0x0000, and 00 otherwise. Here 00 means internal flash boot and 01 means external boot with external masters disabled. With the select input high, the boot configuration is taken from the boot pins. After reset the value holds.
- R8: The censorship word is sampled only while reset is asserted. Changing it afterwards does not alter permission or boot configuration.
- R9: Address 0 is the control register, with bit 0 = PGM, bit 1 = ERS and bit 2 = STOP. Every write there loads PGM and ERS.
- R10: A write to address 0 leaves STOP unchanged if PGM or ERS is 1 before the write.
- R11: The stop output equals STOP. Writing STOP to 0 while PGM and ERS are both 0 ends stop mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pin_sel_i | input | 1 | 1: boot configuration comes from the pins; 0: censorship default |
| boot_pins_i | input | 2 | Boot configuration pins |
| censor_word_i | input | 32 | Censorship control word, sampled during reset |
| ext_master_en_i | input | 1 | External-master enable bit |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register word address |
| wr_data_i | input | 32 | Write data |
| apr_o | output | 32 | Access-protection register, one byte per master |
| wr_denied_o | output | 1 | One-cycle pulse after a refused protection write |
| boot_cfg_o | output | 2 | Captured boot configuration |
| pgm_o | output | 1 | PGM bit |
| ers_o | output | 1 | ERS bit |
| stop_o | output | 1 | Stop indication to the flash current sources |

## Verification
Protection writes are repeated over resets that produce each boot configuration. These come from the default path with lower halves 0xFFFF, 0x0000 and an ordinary value, and from the pin path with values 01, 10 and 11. Each is paired with a key or no key in the upper half, and external-master enable is tried at both values. This separates a permission that looks at the key from one that looks at the boot mode or the enable bit. Changing the word after reset shows whether the sample was truly held. On the control register, a sequence of writes sets and clears PGM, ERS and STOP in different orders. This separates a STOP interlock that uses the pre-write state from one that uses the written data.

// File: rtl/flash_censor_pkg.sv
package flash_censor_pkg;
  localparam logic [1:0]  BOOT_INTERNAL   = 2'b00;
  localparam logic [1:0]  BOOT_EXT_LOCKED = 2'b01;
  localparam logic [15:0] UNLOCK_KEY      = 16'h55AA;
  localparam int          MCR_ADDR        = 0;
  localparam int          APR_ADDR        = 1;
  localparam int          BIT_PGM         = 0;
  localparam int          BIT_ERS         = 1;
  localparam int          BIT_STOP        = 2;

  function automatic logic [1:0] censor_boot_default(input logic [15:0] lo);
    return (lo == 16'hFFFF || lo == 16'h0000) ? BOOT_EXT_LOCKED : BOOT_INTERNAL;
  endfunction
endpackage

// File: rtl/fc_boot_latch.sv
module fc_boot_latch
  import flash_censor_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_pin_sel_i,
  input  logic [1:0]        boot_pins_i,
  input  logic [WORD_W-1:0] censor_word_i,
  output logic [1:0]        boot_cfg_o,
  output logic              key_ok_o
);
  localparam int HALF = WORD_W / 2;

  logic [1:0] boot_q;
  logic       key_q;

  // Sampling happens only while reset is held; the values freeze afterwards.
  always_ff @(posedge clk) begin
    if (rst) begin
      key_q  <= (censor_word_i[WORD_W-1:HALF] == UNLOCK_KEY);
      boot_q <= cfg_pin_sel_i ? boot_pins_i
                              : censor_boot_default(censor_word_i[HALF-1:0]);
    end
  end

  assign boot_cfg_o = boot_q;
  assign key_ok_o   = key_q;
endmodule

// File: rtl/fc_apr_reg.sv
module fc_apr_reg #(
  parameter int NUM_MST = 4,
  parameter int FIELD_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_i,
  input  logic [NUM_MST*FIELD_W-1:0] data_i,
  input  logic                       allow_i,
  output logic [NUM_MST*FIELD_W-1:0] apr_o,
  output logic                       denied_o
);
  logic [FIELD_W-1:0] field_q [NUM_MST];
  logic               denied_q;

  for (genvar k = 0; k < NUM_MST; k++) begin : g_field
    if (k == 0) begin : g_core
      always_ff @(posedge clk) begin
        if (rst)       field_q[k] <= '0;
        else if (wr_i) field_q[k] <= data_i[k*FIELD_W +: FIELD_W];
      end
    end else begin : g_other
      always_ff @(posedge clk) begin
        if (rst)                  field_q[k] <= '0;
        else if (wr_i && allow_i) field_q[k] <= data_i[k*FIELD_W +: FIELD_W];
      end
    end
    assign apr_o[k*FIELD_W +: FIELD_W] = field_q[k];
  end

  always_ff @(posedge clk) begin
    if (rst) denied_q <= 1'b0;
    else     denied_q <= wr_i && !allow_i;
  end

  assign denied_o = denied_q;
endmodule

// File: rtl/fc_mcr_reg.sv
module fc_mcr_reg
  import flash_censor_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_i,
  input  logic [2:0] data_i,
  output logic       pgm_o,
  output logic       ers_o,
  output logic       stop_o
);
  logic pgm_q, ers_q, stop_q;
  logic stop_lock;

  assign stop_lock = pgm_q || ers_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pgm_q  <= 1'b0;
      ers_q  <= 1'b0;
      stop_q <= 1'b0;
    end else if (wr_i) begin
      pgm_q <= data_i[BIT_PGM];
      ers_q <= data_i[BIT_ERS];
      if (!stop_lock) stop_q <= data_i[BIT_STOP];
    end
  end

  assign pgm_o  = pgm_q;
  assign ers_o  = ers_q;
  assign stop_o = stop_q;
endmodule

// File: rtl/flash_censor_ctrl.sv
module flash_censor_ctrl
  import flash_censor_pkg::*;
#(
  parameter int NUM_MST = 4,
  parameter int FIELD_W = 8,
  parameter int ADDR_W  = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_pin_sel_i,
  input  logic [1:0]                 boot_pins_i,
  input  logic [31:0]                censor_word_i,
  input  logic                       ext_master_en_i,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [NUM_MST*FIELD_W-1:0] wr_data_i,
  output logic [NUM_MST*FIELD_W-1:0] apr_o,
  output logic                       wr_denied_o,
  output logic [1:0]                 boot_cfg_o,
  output logic                       pgm_o,
  output logic                       ers_o,
  output logic                       stop_o
);
  logic key_ok;
  logic allow;
  logic wr_apr, wr_mcr;

  assign wr_apr = wr_en_i && (wr_addr_i == ADDR_W'(APR_ADDR));
  assign wr_mcr = wr_en_i && (wr_addr_i == ADDR_W'(MCR_ADDR));

  fc_boot_latch #(.WORD_W(32)) boot_i (
    .clk           (clk),
    .rst           (rst),
    .cfg_pin_sel_i (cfg_pin_sel_i),
    .boot_pins_i   (boot_pins_i),
    .censor_word_i (censor_word_i),
    .boot_cfg_o    (boot_cfg_o),
    .key_ok_o      (key_ok)
  );

  // Censorship rule for the non-core fields.
  assign allow = !ext_master_en_i || ((boot_cfg_o != BOOT_EXT_LOCKED) && key_ok);

  fc_apr_reg #(.NUM_MST(NUM_MST), .FIELD_W(FIELD_W)) apr_i (
    .clk      (clk),
    .rst      (rst),
    .wr_i     (wr_apr),
    .data_i   (wr_data_i),
    .allow_i  (allow),
    .apr_o    (apr_o),
    .denied_o (wr_denied_o)
  );

  fc_mcr_reg mcr_i (
    .clk    (clk),
    .rst    (rst),
    .wr_i   (wr_mcr),
    .data_i (wr_data_i[2:0]),
    .pgm_o  (pgm_o),
    .ers_o  (ers_o),
    .stop_o (stop_o)
  );
endmodule

// File: rtl/flash_censor_chk.sv
module flash_censor_chk #(
  parameter int NUM_MST = 4,
  parameter int FIELD_W = 8,
  parameter int ADDR_W  = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       ext_master_en_i,
  input logic                       wr_en_i,
  input logic [ADDR_W-1:0]          wr_addr_i,
  input logic [NUM_MST*FIELD_W-1:0] wr_data_i,
  input logic [NUM_MST*FIELD_W-1:0] apr_o,
  input logic                       wr_denied_o,
  input logic [1:0]                 boot_cfg_o,
  input logic                       pgm_o,
  input logic                       ers_o,
  input logic                       stop_o
);
  localparam int DATA_W = NUM_MST * FIELD_W;

  logic apr_wr, mcr_wr;
  assign apr_wr = wr_en_i && (wr_addr_i == ADDR_W'(1));
  assign mcr_wr = wr_en_i && (wr_addr_i == ADDR_W'(0));

  // R2
  core_field_chk: assert property (@(posedge clk) disable iff (rst)
    apr_wr |=> apr_o[FIELD_W-1:0] == $past(wr_data_i[FIELD_W-1:0]));

  // R3
  open_write_chk: assert property (@(posedge clk) disable iff (rst)
    (apr_wr && !ext_master_en_i) |=> (apr_o == $past(wr_data_i)) && !wr_denied_o);

  // R5
  locked_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (apr_wr && ext_master_en_i && boot_cfg_o == 2'b01) |=>
      wr_denied_o && (apr_o[DATA_W-1:FIELD_W] == $past(apr_o[DATA_W-1:FIELD_W])));

  // R6
  denied_cause_chk: assert property (@(posedge clk) disable iff (rst)
    wr_denied_o |-> $past(apr_wr && ext_master_en_i));

  // R7
  boot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(boot_cfg_o));

  // R9
  pgm_ers_chk: assert property (@(posedge clk) disable iff (rst)
    mcr_wr |=> (pgm_o == $past(wr_data_i[0])) && (ers_o == $past(wr_data_i[1])));

  // R10
  stop_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (mcr_wr && (pgm_o || ers_o)) |=> $stable(stop_o));
endmodule

bind flash_censor_ctrl flash_censor_chk #(
  .NUM_MST(NUM_MST), .FIELD_W(FIELD_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk             (clk),
  .rst             (rst),
  .ext_master_en_i (ext_master_en_i),
  .wr_en_i         (wr_en_i),
  .wr_addr_i       (wr_addr_i),
  .wr_data_i       (wr_data_i),
  .apr_o           (apr_o),
  .wr_denied_o     (wr_denied_o),
  .boot_cfg_o      (boot_cfg_o),
  .pgm_o           (pgm_o),
  .ers_o           (ers_o),
  .stop_o          (stop_o)
);

// File: tb/flash_censor_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_censor_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_pin_sel = 1'b0;
  logic [1:0]  boot_pins = 2'b00;
  logic [31:0] cword = 32'h0;
  logic        extm = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = 4'h0;
  logic [31:0] wr_data = 32'h0;
  logic [31:0] apr;
  logic        denied, pgm, ers, stop;
  logic [1:0]  boot;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  flash_censor_ctrl dut_i (
    .clk(clk), .rst(rst), .cfg_pin_sel_i(cfg_pin_sel), .boot_pins_i(boot_pins),
    .censor_word_i(cword), .ext_master_en_i(extm), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .apr_o(apr), .wr_denied_o(denied),
    .boot_cfg_o(boot), .pgm_o(pgm), .ers_o(ers), .stop_o(stop)
  );

  // Behavioural reference model, advanced on every rising edge.
  logic [31:0] m_apr;
  logic        m_den, m_pgm, m_ers, m_stop, m_key, m_started = 1'b0;
  logic [1:0]  m_boot;

  always @(posedge clk) begin
    m_started = 1'b1;
    if (rst) begin
      m_apr = 0; m_den = 0; m_pgm = 0; m_ers = 0; m_stop = 0;
      m_key = (cword[31:16] == 16'h55AA);
      if (cfg_pin_sel)                                      m_boot = boot_pins;
      else if (cword[15:0] == 16'hFFFF || cword[15:0] == 0) m_boot = 2'b01;
      else                                                  m_boot = 2'b00;
    end else begin
      bit ok;
      bit lock;
      ok = (extm == 1'b0) || (m_boot != 2'b01 && m_key);
      lock = m_pgm || m_ers;
      m_den = 0;
      if (wr_en && wr_addr == 4'd1) begin
        m_apr[7:0] = wr_data[7:0];
        if (ok) m_apr = wr_data;
        m_den = !ok;
      end
      if (wr_en && wr_addr == 4'd0) begin
        m_pgm = wr_data[0];
        m_ers = wr_data[1];
        if (!lock) m_stop = wr_data[2];
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the rising edge.
  always @(negedge clk) begin
    if (m_started) begin
      check("R2 apr model", apr, m_apr);
      check("R6 denied model", {31'd0, denied}, {31'd0, m_den});
      check("R7 boot model", {30'd0, boot}, {30'd0, m_boot});
      check("R9 pgm/ers model", {30'd0, pgm, ers}, {30'd0, m_pgm, m_ers});
      check("R11 stop model", {31'd0, stop}, {31'd0, m_stop});
    end
  end

  task automatic do_reset(input logic sel, input logic [1:0] pins, input logic [31:0] w);
    @(negedge clk);
    rst = 1'b1; cfg_pin_sel = sel; boot_pins = pins; cword = w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // Default path, lower half all-ones: locked external boot
    do_reset(1'b0, 2'b00, 32'h55AA_FFFF);
    check("R1 apr reset", apr, 32'h0);
    check("R1 mcr reset", {29'd0, stop, ers, pgm}, 32'h0);
    check("R1 denied reset", {31'd0, denied}, 32'h0);
    check("R7 ffff default", {30'd0, boot}, 32'h1);
    extm = 1'b1;
    wr(4'd1, 32'hA1B2_C3D4);
    check("R5 locked keeps non-core", apr, 32'h0000_00D4);
    check("R6 denied pulse", {31'd0, denied}, 32'h1);
    @(negedge clk);
    check("R6 denied one cycle", {31'd0, denied}, 32'h0);
    extm = 1'b0;
    wr(4'd1, 32'h1122_3344);
    check("R3 open write", apr, 32'h1122_3344);

    // Default path, ordinary lower half, key present
    do_reset(1'b0, 2'b00, 32'h55AA_1234);
    check("R7 internal default", {30'd0, boot}, 32'h0);
    extm = 1'b1;
    wr(4'd1, 32'hCAFE_BABE);
    check("R4 key allows", apr, 32'hCAFE_BABE);
    cword = 32'h0000_FFFF;
    wr(4'd1, 32'h0102_0304);
    check("R8 runtime word ignored", apr, 32'h0102_0304);
    check("R8 boot held", {30'd0, boot}, 32'h0);

    // No key, internal boot
    do_reset(1'b0, 2'b00, 32'h0000_1234);
    wr(4'd1, 32'hDEAD_BEEF);
    check("R4 no key blocks", apr, 32'h0000_00EF);
    check("R2 core field", {24'd0, apr[7:0]}, 32'hEF);

    // Pin path
    do_reset(1'b1, 2'b11, 32'h55AA_0000);
    check("R7 pins 11", {30'd0, boot}, 32'h3);
    wr(4'd1, 32'h1234_5678);
    check("R4 boot 11 key", apr, 32'h1234_5678);
    do_reset(1'b1, 2'b10, 32'h1234_FFFF);
    check("R7 pins 10", {30'd0, boot}, 32'h2);
    wr(4'd1, 32'h1234_5678);
    check("R4 boot 10 no key", apr, 32'h0000_0078);
    do_reset(1'b1, 2'b01, 32'h55AA_5555);
    wr(4'd1, 32'hFFFF_FFFF);
    check("R5 pins 01 with key", apr, 32'h0000_00FF);

    // Default path, lower half all-zeros
    do_reset(1'b0, 2'b11, 32'h55AA_0000);
    check("R7 zero default", {30'd0, boot}, 32'h1);

    // Control register interlock
    extm = 1'b0;
    wr(4'd0, 32'h1);
    check("R9 pgm set", {31'd0, pgm}, 32'h1);
    wr(4'd0, 32'h5);
    check("R10 stop blocked by pgm", {31'd0, stop}, 32'h0);
    wr(4'd0, 32'h0);
    wr(4'd0, 32'h4);
    check("R11 stop on", {31'd0, stop}, 32'h1);
    wr(4'd0, 32'h6);
    check("R9 ers set", {31'd0, ers}, 32'h1);
    wr(4'd0, 32'h0);
    check("R10 clear blocked by ers", {31'd0, stop}, 32'h1);
    wr(4'd0, 32'h0);
    check("R11 stop off", {31'd0, stop}, 32'h0);

    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule